// File: doc/BRIEF.md
# Core Low-Power State Sequencer

This block sequences one processor core through four power modes: run, doze, nap and sleep. From its state it drives the enables for the core clock, the time-base clock and the I/O clock. It also drives a flag that lets the core answer coherency snoops and a flag that lets the core dispatch instructions. Two pins report the current mode off chip.

Software asks for a mode by placing a 2-bit code on `mode_req` with `req_valid` high. Doze takes effect on the next edge. Nap and sleep first raise `flush_req` and wait for `flush_done` from the data-cache flush logic. Clocks are gated only after that handshake. A wake event or a pending interrupt during that wait cancels the entry.

In any low-power mode, a pending interrupt or a wake event turns every clock back on. The core then spends a fixed settle window with dispatch held off before it returns to run. A request made while the core is in a low-power mode is ignored, so reaching a different low-power mode always goes through run.

Top module: `core_pwr_seq`

## Requirements
- R1: During and after reset the block is in run: all three clock enables, `snoop_en` and `dispatch_en` are 1, `flush_req` is 0 and `mode_pins` is 00.
- R2: `mode_pins` encodes the mode as run 00, doze 01, nap 10, sleep 11. The code is updated on the same edge as the clock enables.
- R3: A doze request (`mode_req`=01) accepted in run enters doze on the next edge. In doze all clocks stay on, `snoop_en` is 1 and `dispatch_en` is 0.
- R4: A nap (10) or sleep (11) request accepted in run raises `flush_req` on the next edge. While `flush_req` is high, all clocks and `snoop_en` stay on, `dispatch_en` is 0 and `mode_pins` is 00. The first edge with `flush_done` high enters the requested mode.
- R5: In nap the core clock is off, the time-base and I/O clocks are on, and `snoop_en` is 0.
- R6: In sleep the core, time-base and I/O clocks are all off, and `snoop_en` is 0.
- R7: In doze, nap or sleep, `irq_pending` or `wake_evt` turns all three clocks on at the next edge. For SETTLE_CYCLES (default 4) cycles `dispatch_en` and `snoop_en` stay 0 and `mode_pins` keeps the code of the mode being left. The block is then back in run.
- R8: `irq_pending` or `wake_evt` while `flush_req` is high returns the block to run on the next edge, even if `flush_done` is high in the same cycle.
- R9: Requests made in doze, nap, sleep or the settle window have no effect. A request for code 00 in run has no effect. No low-power mode moves directly to a different low-power mode.
- R10: `mode_req` is ignored whenever `req_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Qualifies `mode_req` |
| mode_req | input | 2 | Requested mode code (01 doze, 10 nap, 11 sleep) |
| flush_done | input | 1 | Data-cache flush has completed |
| irq_pending | input | 1 | An interrupt is pending for the core |
| wake_evt | input | 1 | External wake event |
| core_clk_en | output | 1 | Enable for the core clock |
| tb_clk_en | output | 1 | Enable for the time-base clock |
| io_clk_en | output | 1 | Enable for the I/O clocks |
| snoop_en | output | 1 | Core answers snoops |
| dispatch_en | output | 1 | Core may dispatch instructions |
| flush_req | output | 1 | Request to flush the data cache |
| mode_pins | output | 2 | Reported power mode |

## Verification
The two functions that can meet in one cycle are completion of the flush handshake and the wake/interrupt abort. A nap request is issued, and on the edge where `flush_done` first rises, `wake_evt` is raised as well. The outputs sampled after that edge must show run, not nap, and the next edge must not drift into nap. A second race sends a new request in the same cycle that a low-power mode is woken. The settle window must run its full length, and the block must come back to run rather than to the newly requested mode.

// File: rtl/cps_pkg.sv
package cps_pkg;

  typedef enum logic [2:0] {
    S_RUN,
    S_DOZE,
    S_FLUSH,
    S_NAP,
    S_SLEEP,
    S_SETTLE
  } pstate_e;

  localparam logic [1:0] PM_RUN   = 2'b00;
  localparam logic [1:0] PM_DOZE  = 2'b01;
  localparam logic [1:0] PM_NAP   = 2'b10;
  localparam logic [1:0] PM_SLEEP = 2'b11;

  typedef struct packed {
    logic       core_clk_en;
    logic       tb_clk_en;
    logic       io_clk_en;
    logic       snoop_en;
    logic       dispatch_en;
    logic       flush_req;
    logic [1:0] mode_pins;
  } pwr_out_t;

  localparam pwr_out_t OUT_RUN = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, PM_RUN};

endpackage

// File: rtl/cps_settle_timer.sv
module cps_settle_timer #(
  parameter int SETTLE_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic done
);
  localparam int CW = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES + 1) : 1;
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (start) begin
      cnt_q <= '0;
    end else if (cnt_q != LAST) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done = (cnt_q == LAST);
endmodule

// File: rtl/cps_out_map.sv
module cps_out_map
  import cps_pkg::*;
(
  input  pstate_e  st,
  input  logic [1:0] lp_code,
  output pwr_out_t o
);
  always_comb begin
    o = OUT_RUN;
    unique case (st)
      S_RUN: o = OUT_RUN;
      S_DOZE: begin
        o.dispatch_en = 1'b0;
        o.mode_pins   = PM_DOZE;
      end
      S_FLUSH: begin
        o.dispatch_en = 1'b0;
        o.flush_req   = 1'b1;
      end
      S_NAP: begin
        o.core_clk_en = 1'b0;
        o.snoop_en    = 1'b0;
        o.dispatch_en = 1'b0;
        o.mode_pins   = PM_NAP;
      end
      S_SLEEP: begin
        o.core_clk_en = 1'b0;
        o.tb_clk_en   = 1'b0;
        o.io_clk_en   = 1'b0;
        o.snoop_en    = 1'b0;
        o.dispatch_en = 1'b0;
        o.mode_pins   = PM_SLEEP;
      end
      S_SETTLE: begin
        o.snoop_en    = 1'b0;
        o.dispatch_en = 1'b0;
        o.mode_pins   = lp_code;
      end
      default: o = OUT_RUN;
    endcase
  end
endmodule

// File: rtl/core_pwr_seq.sv
module core_pwr_seq
  import cps_pkg::*;
#(
  parameter int SETTLE_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  input  logic [1:0] mode_req,
  input  logic       flush_done,
  input  logic       irq_pending,
  input  logic       wake_evt,
  output logic       core_clk_en,
  output logic       tb_clk_en,
  output logic       io_clk_en,
  output logic       snoop_en,
  output logic       dispatch_en,
  output logic       flush_req,
  output logic [1:0] mode_pins
);
  pstate_e    st_q, st_d;
  logic [1:0] tgt_q, tgt_d;
  logic [1:0] lp_q, lp_d;
  logic       settle_start, settle_done, wake;
  pwr_out_t   out_d, out_q;

  assign wake = irq_pending | wake_evt;

  cps_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .start(settle_start),
    .done (settle_done)
  );

  always_comb begin
    st_d         = st_q;
    tgt_d        = tgt_q;
    lp_d         = lp_q;
    settle_start = 1'b0;
    unique case (st_q)
      S_RUN: begin
        if (req_valid) begin
          unique case (mode_req)
            PM_DOZE: begin
              st_d = S_DOZE;
              lp_d = PM_DOZE;
            end
            PM_NAP, PM_SLEEP: begin
              st_d  = S_FLUSH;
              tgt_d = mode_req;
            end
            default: st_d = S_RUN;
          endcase
        end
      end
      S_DOZE, S_NAP, S_SLEEP: begin
        if (wake) begin
          st_d         = S_SETTLE;
          settle_start = 1'b1;
        end
      end
      S_FLUSH: begin
        if (wake) begin
          st_d = S_RUN;
        end else if (flush_done) begin
          st_d = (tgt_q == PM_SLEEP) ? S_SLEEP : S_NAP;
          lp_d = tgt_q;
        end
      end
      S_SETTLE: begin
        if (settle_done) st_d = S_RUN;
      end
      default: st_d = S_RUN;
    endcase
  end

  cps_out_map u_map (
    .st     (st_d),
    .lp_code(lp_d),
    .o      (out_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= S_RUN;
      tgt_q <= PM_NAP;
      lp_q  <= PM_RUN;
      out_q <= OUT_RUN;
    end else begin
      st_q  <= st_d;
      tgt_q <= tgt_d;
      lp_q  <= lp_d;
      out_q <= out_d;
    end
  end

  assign core_clk_en = out_q.core_clk_en;
  assign tb_clk_en   = out_q.tb_clk_en;
  assign io_clk_en   = out_q.io_clk_en;
  assign snoop_en    = out_q.snoop_en;
  assign dispatch_en = out_q.dispatch_en;
  assign flush_req   = out_q.flush_req;
  assign mode_pins   = out_q.mode_pins;
endmodule

// File: rtl/cps_checker.sv
module cps_checker (
  input logic       clk,
  input logic       rst,
  input logic       flush_done,
  input logic       irq_pending,
  input logic       wake_evt,
  input logic       core_clk_en,
  input logic       tb_clk_en,
  input logic       io_clk_en,
  input logic       snoop_en,
  input logic       dispatch_en,
  input logic       flush_req,
  input logic [1:0] mode_pins
);
  a_r1_reset_run: assert property (@(posedge clk)
    rst |=> (core_clk_en && tb_clk_en && io_clk_en && dispatch_en && !flush_req && mode_pins == 2'b00));

  a_r4_flush_wait_run_code: assert property (@(posedge clk) disable iff (rst)
    flush_req |-> (mode_pins == 2'b00 && core_clk_en && snoop_en && !dispatch_en));

  a_r4_gate_after_flush: assert property (@(posedge clk) disable iff (rst)
    $fell(core_clk_en) |-> ($past(flush_req) && $past(flush_done)));

  a_r5_nap_rules: assert property (@(posedge clk) disable iff (rst)
    (mode_pins == 2'b10 && !core_clk_en) |-> (tb_clk_en && io_clk_en && !snoop_en));

  a_r6_sleep_rules: assert property (@(posedge clk) disable iff (rst)
    (mode_pins == 2'b11 && !core_clk_en) |-> (!tb_clk_en && !io_clk_en && !snoop_en));

  a_r7_wake_restores: assert property (@(posedge clk) disable iff (rst)
    (!core_clk_en && (irq_pending || wake_evt)) |=> (core_clk_en && tb_clk_en && io_clk_en && !dispatch_en));

  a_r8_abort_to_run: assert property (@(posedge clk) disable iff (rst)
    (flush_req && (irq_pending || wake_evt)) |=> (!flush_req && mode_pins == 2'b00 && dispatch_en));

  a_r9_no_direct_lowpower_hop: assert property (@(posedge clk) disable iff (rst)
    ($past(mode_pins) != 2'b00 && mode_pins != 2'b00) |-> (mode_pins == $past(mode_pins)));

  a_r2_dispatch_only_in_run: assert property (@(posedge clk) disable iff (rst)
    dispatch_en |-> (mode_pins == 2'b00 && !flush_req && core_clk_en));
endmodule

bind core_pwr_seq cps_checker chk_i (
  .clk        (clk),
  .rst        (rst),
  .flush_done (flush_done),
  .irq_pending(irq_pending),
  .wake_evt   (wake_evt),
  .core_clk_en(core_clk_en),
  .tb_clk_en  (tb_clk_en),
  .io_clk_en  (io_clk_en),
  .snoop_en   (snoop_en),
  .dispatch_en(dispatch_en),
  .flush_req  (flush_req),
  .mode_pins  (mode_pins)
);

// File: tb/core_pwr_seq_tb_top.sv
`timescale 1ns/1ps
module core_pwr_seq_tb_top;
  localparam int SETTLE = 4;

  // packed view: {core, tb, io, snoop, dispatch, flush, pins[1:0]}
  localparam logic [7:0] E_RUN    = 8'b1111_1000;
  localparam logic [7:0] E_DOZE   = 8'b1111_0001;
  localparam logic [7:0] E_FLUSH  = 8'b1111_0100;
  localparam logic [7:0] E_NAP    = 8'b0110_0010;
  localparam logic [7:0] E_SLEEP  = 8'b0000_0011;
  localparam logic [7:0] E_SET_DZ = 8'b1110_0001;
  localparam logic [7:0] E_SET_NP = 8'b1110_0010;
  localparam logic [7:0] E_SET_SL = 8'b1110_0011;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [1:0] mode_req = 2'b00;
  logic flush_done = 1'b0;
  logic irq_pending = 1'b0;
  logic wake_evt = 1'b0;
  logic core_clk_en, tb_clk_en, io_clk_en, snoop_en, dispatch_en, flush_req;
  logic [1:0] mode_pins;
  int nvec = 0;
  int nbad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  core_pwr_seq #(.SETTLE_CYCLES(SETTLE)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .mode_req(mode_req),
    .flush_done(flush_done), .irq_pending(irq_pending), .wake_evt(wake_evt),
    .core_clk_en(core_clk_en), .tb_clk_en(tb_clk_en), .io_clk_en(io_clk_en),
    .snoop_en(snoop_en), .dispatch_en(dispatch_en), .flush_req(flush_req),
    .mode_pins(mode_pins)
  );

  wire [7:0] obs = {core_clk_en, tb_clk_en, io_clk_en, snoop_en, dispatch_en, flush_req, mode_pins};

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [7:0] exp);
    nvec++;
    if (obs !== exp) begin
      nbad++;
      $display("FAIL %s: got %b expected %b at %0t", tag, obs, exp, $time);
    end
  endtask

  task automatic request(input logic [1:0] code);
    req_valid = 1'b1;
    mode_req  = code;
    tick();
    req_valid = 1'b0;
    mode_req  = 2'b00;
  endtask

  task automatic settle_out(input string tag, input logic [7:0] exp_settle);
    for (int i = 0; i < SETTLE - 1; i++) begin
      tick();
      chk(tag, exp_settle);
    end
    tick();
    chk(tag, E_RUN);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    tick();
    chk("R1 in reset", E_RUN);
    tick();
    rst = 1'b0;
    tick();
    chk("R1 after reset", E_RUN);
  endtask

  task automatic t_doze();
    request(2'b01);
    chk("R3 R2 doze entry", E_DOZE);
    tick();
    chk("R3 doze held", E_DOZE);
    irq_pending = 1'b1;
    tick();
    irq_pending = 1'b0;
    chk("R7 doze wake", E_SET_DZ);
    settle_out("R7 doze settle", E_SET_DZ);
  endtask

  task automatic t_nap();
    request(2'b10);
    chk("R4 nap flush req", E_FLUSH);
    tick();
    tick();
    chk("R4 flush wait held", E_FLUSH);
    flush_done = 1'b1;
    tick();
    flush_done = 1'b0;
    chk("R5 R2 nap entry", E_NAP);
    request(2'b11);
    chk("R9 sleep request in nap ignored", E_NAP);
    request(2'b01);
    chk("R9 doze request in nap ignored", E_NAP);
    wake_evt = 1'b1;
    tick();
    wake_evt = 1'b0;
    chk("R7 nap wake", E_SET_NP);
    settle_out("R7 nap settle", E_SET_NP);
  endtask

  task automatic t_sleep();
    request(2'b11);
    chk("R4 sleep flush req", E_FLUSH);
    flush_done = 1'b1;
    tick();
    flush_done = 1'b0;
    chk("R6 R2 sleep entry", E_SLEEP);
    tick();
    chk("R6 sleep held", E_SLEEP);
    irq_pending = 1'b1;
    req_valid = 1'b1;
    mode_req = 2'b10;
    tick();
    irq_pending = 1'b0;
    req_valid = 1'b0;
    mode_req = 2'b00;
    chk("R7 sleep wake with request", E_SET_SL);
    req_valid = 1'b1;
    mode_req = 2'b01;
    tick();
    req_valid = 1'b0;
    mode_req = 2'b00;
    chk("R9 request in settle ignored", E_SET_SL);
    tick();
    chk("R7 sleep settle", E_SET_SL);
    tick();
    chk("R7 sleep settle last", E_SET_SL);
    tick();
    chk("R7 R9 back to run", E_RUN);
    tick();
    chk("R9 stays run", E_RUN);
  endtask

  task automatic t_abort();
    request(2'b11);
    chk("R4 sleep flush req", E_FLUSH);
    wake_evt = 1'b1;
    tick();
    wake_evt = 1'b0;
    chk("R8 abort by wake", E_RUN);
    request(2'b10);
    irq_pending = 1'b1;
    tick();
    irq_pending = 1'b0;
    chk("R8 abort by irq", E_RUN);
  endtask

  task automatic t_abort_race();
    request(2'b10);
    chk("R4 nap flush req", E_FLUSH);
    wake_evt = 1'b1;
    flush_done = 1'b1;
    tick();
    wake_evt = 1'b0;
    flush_done = 1'b0;
    chk("R8 abort beats flush_done", E_RUN);
    tick();
    chk("R8 no late nap", E_RUN);
  endtask

  task automatic t_invalid();
    mode_req = 2'b10;
    tick();
    chk("R10 no valid no entry", E_RUN);
    mode_req = 2'b00;
    request(2'b00);
    chk("R9 run code ignored", E_RUN);
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      nvec++;
      nbad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    #1;
    t_reset();
    t_doze();
    t_nap();
    t_sleep();
    t_abort();
    t_abort_race();
    t_invalid();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule